// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects interrupt requests from four external pins, a group of main sources and a group of peripheral sources. It reduces them to one registered status word and one request line to the processor. Each external pin goes through a two-flop synchronizer and then through its own sense selection: active-high level, active-low level, rising edge or falling edge. A pin set to an edge sense holds the event in a sticky latch until software clears it. Main and peripheral sources can each be masked one at a time. Their mask bits are stored in reversed order, so source n sits at the top bit of its field minus n.

Sources fall into three classes: critical, main and peripheral. External pin 0 is the only critical source. External pins 1 to 3 are merged into main sources 1 to 3. Each cycle the controller picks the highest pending class. Within that class it picks the lowest-numbered pending source. The status word then shows the class flag, the index field of that class, and a flat source number in the low byte. The processor request is raised while any class flag is set.

A small register bus with four word addresses gives access to the pin control register, the two mask registers and the status word. Reads are combinational.

Top module: `ic_top`

## Requirements
- R1: After reset, the control and both mask registers read as zero, the status word is zero and `irq` is low.
- R2: The control register (address 0) holds the enable bit of pin n at bit 11-n and the 2-bit sense field of pin n at bits 23-2n:22-2n. All other bits read as zero, including the clear bits 27:24.
- R3: Sense code 00 makes a pin active while it is high and code 11 while it is low. A level change shows in the status word three clocks after it reaches the pin (two synchronizer flops plus the status register).
- R4: Sense code 01 (rising) or 10 (falling) sets a sticky latch on the matching synchronized edge. The request stays after the pin returns. Writing 1 to control bit 27-n clears the latch of pin n, and writing 0 there leaves it set.
- R5: A pin whose enable bit is 0 produces no request, whatever its level or latch.
- R6: An active pin 0 is the critical class. It sets status bit 10 with index bits 9:8 = 0 and source number bits 7:0 = 0x00.
- R7: Main source n is masked while bit 16-n of the main-mask register (address 1) is 1. Only bits 16:0 are stored. Pins 1 to 3 are ORed into main sources 1 to 3. A winning main source sets status bit 21, puts its index in bits 20:16, and sets bits 7:0 to class 1 in bits 7:6 with the index in bits 5:0.
- R8: Peripheral source n is masked while bit 31-n of the peripheral-mask register (address 2) is 1. Only bits 31:8 are stored. A winning peripheral source sets status bit 29, puts its index in bits 28:24, and sets bits 7:0 to class 2 in bits 7:6 with the index in bits 5:0.
- R9: Critical beats main and main beats peripheral. At most one class flag is set in the status word.
- R10: Within a class, the lowest-numbered unmasked pending source wins.
- R11: `irq` is high exactly when a class flag is set. A mask write or a change on a main or peripheral source shows in the status word one clock after the edge that takes it in.
- R12: Reading address 3 returns the status word. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Register access select |
| busWe | input | 1 | Write enable (with busSel) |
| busAddr | input | 2 | Word address: 0 control, 1 main mask, 2 peripheral mask, 3 status |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| extPin | input | 4 | Asynchronous external interrupt pins |
| mainSrc | input | 17 | Main-class source requests |
| periSrc | input | 24 | Peripheral-class source requests |
| irq | output | 1 | Interrupt request to the processor |
| status | output | 32 | Registered status word |

## Verification
The hardest case to reach is a sticky edge latch that must outlive its pin pulse. It must stay set through a write of zeros to its clear bit, and vanish only when a one is written there, while a lower-class peripheral source waits underneath. The stimulus first parks a peripheral source as the standing winner. It then pulses pin 1 for a few clocks under rising sense, lowers the pin, writes the control word with the clear bit at zero and later at one, and checks that status moves from the main index back to the peripheral index only after the second write. A behavioural model in the bench follows the synchronizer stages and the latches every clock, so the three-clock pin latency is compared on each cycle, not only at the settled points.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int DATA_W      = 32;
  localparam int NUM_PINS    = 4;
  localparam int EN_TOP      = 11;
  localparam int CLR_TOP     = 27;
  localparam int SENSE_TOP   = 23;
  localparam int PERI_TOP    = 31;
  localparam int CRIT_FLAG   = 10;
  localparam int MAIN_FLAG   = 21;
  localparam int PERI_FLAG   = 29;
  localparam int MAIN_IDX_LO = 16;
  localparam int PERI_IDX_LO = 24;

  localparam logic [1:0] SENSE_HIGH = 2'b00;
  localparam logic [1:0] SENSE_RISE = 2'b01;
  localparam logic [1:0] SENSE_FALL = 2'b10;
  localparam logic [1:0] SENSE_LOW  = 2'b11;

  localparam logic [1:0] CLS_CRIT = 2'd0;
  localparam logic [1:0] CLS_MAIN = 2'd1;
  localparam logic [1:0] CLS_PERI = 2'd2;

  typedef struct packed {
    logic              wrCtrl;
    logic              wrMain;
    logic              wrPeri;
    logic [1:0]        rdSel;
    logic [DATA_W-1:0] wdata;
  } icStrobe_t;

  function automatic logic [4:0] firstSet(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/ic_extpin.sv
module ic_extpin
  import ic_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic       en,
  input  logic [1:0] sense,
  input  logic       clr,
  output logic       req
);
  logic syncA, syncB, prevB, held;
  logic riseEv, fallEv, setEv, active;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= pin;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign riseEv = syncB & ~prevB;
  assign fallEv = ~syncB & prevB;
  assign setEv  = ((sense == SENSE_RISE) & riseEv) | ((sense == SENSE_FALL) & fallEv);

  always_ff @(posedge clk) begin
    if (rst)        held <= 1'b0;
    else if (setEv) held <= 1'b1;
    else if (clr)   held <= 1'b0;
  end

  always_comb begin
    unique case (sense)
      SENSE_HIGH: active = syncB;
      SENSE_LOW:  active = ~syncB;
      default:    active = held;
    endcase
  end

  assign req = en & active;
endmodule

// File: rtl/ic_ctrl.sv
module ic_ctrl
  import ic_pkg::*;
(
  input  logic              busSel,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output icStrobe_t         strb
);
  logic wr;
  assign wr = busSel & busWe;

  always_comb begin
    strb.wrCtrl = wr & (busAddr == 2'd0);
    strb.wrMain = wr & (busAddr == 2'd1);
    strb.wrPeri = wr & (busAddr == 2'd2);
    strb.rdSel  = busAddr;
    strb.wdata  = busWdata;
  end
endmodule

// File: rtl/ic_datapath.sv
module ic_datapath
  import ic_pkg::*;
#(
  parameter int NUM_MAIN = 17,
  parameter int NUM_PERI = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  icStrobe_t           strb,
  input  logic [NUM_PINS-1:0] extPin,
  input  logic [NUM_MAIN-1:0] mainSrc,
  input  logic [NUM_PERI-1:0] periSrc,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   stat
);
  localparam int MAIN_TOP = NUM_MAIN - 1;

  logic [NUM_PINS-1:0] pinEn, pinClr, pinReq;
  logic [1:0]          pinSense [NUM_PINS];
  logic [NUM_MAIN-1:0] mainMask, mainPend;
  logic [NUM_PERI-1:0] periMask, periPend;
  logic [DATA_W-1:0]   ctrlWord, mainWord, periWord, statNext;
  logic [4:0]          mainIdx, periIdx;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pin
      assign pinClr[g] = strb.wrCtrl & strb.wdata[CLR_TOP-g];

      always_ff @(posedge clk) begin
        if (rst) begin
          pinEn[g]    <= 1'b0;
          pinSense[g] <= SENSE_HIGH;
        end else if (strb.wrCtrl) begin
          pinEn[g]    <= strb.wdata[EN_TOP-g];
          pinSense[g] <= strb.wdata[SENSE_TOP-2*g -: 2];
        end
      end

      ic_extpin u_pin (
        .clk  (clk),
        .rst  (rst),
        .pin  (extPin[g]),
        .en   (pinEn[g]),
        .sense(pinSense[g]),
        .clr  (pinClr[g]),
        .req  (pinReq[g])
      );
    end

    for (g = 0; g < NUM_MAIN; g++) begin : g_main
      always_ff @(posedge clk) begin
        if (rst)              mainMask[g] <= 1'b0;
        else if (strb.wrMain) mainMask[g] <= strb.wdata[MAIN_TOP-g];
      end
      if (g >= 1 && g < NUM_PINS) begin : g_merge
        assign mainPend[g] = (mainSrc[g] | pinReq[g]) & ~mainMask[g];
      end else begin : g_plain
        assign mainPend[g] = mainSrc[g] & ~mainMask[g];
      end
    end

    for (g = 0; g < NUM_PERI; g++) begin : g_peri
      always_ff @(posedge clk) begin
        if (rst)              periMask[g] <= 1'b0;
        else if (strb.wrPeri) periMask[g] <= strb.wdata[PERI_TOP-g];
      end
      assign periPend[g] = periSrc[g] & ~periMask[g];
    end
  endgenerate

  always_comb begin
    ctrlWord = '0;
    mainWord = '0;
    periWord = '0;
    for (int n = 0; n < NUM_PINS; n++) begin
      ctrlWord[EN_TOP-n]            = pinEn[n];
      ctrlWord[SENSE_TOP-2*n -: 2]  = pinSense[n];
    end
    for (int n = 0; n < NUM_MAIN; n++) mainWord[MAIN_TOP-n] = mainMask[n];
    for (int n = 0; n < NUM_PERI; n++) periWord[PERI_TOP-n] = periMask[n];
  end

  assign mainIdx = firstSet(32'(mainPend));
  assign periIdx = firstSet(32'(periPend));

  always_comb begin
    statNext = '0;
    if (pinReq[0]) begin
      statNext[CRIT_FLAG] = 1'b1;
      statNext[7:0]       = {CLS_CRIT, 6'd0};
    end else if (|mainPend) begin
      statNext[MAIN_FLAG]                    = 1'b1;
      statNext[MAIN_IDX_LO +: 5]             = mainIdx;
      statNext[7:0]                          = {CLS_MAIN, 1'b0, mainIdx};
    end else if (|periPend) begin
      statNext[PERI_FLAG]                    = 1'b1;
      statNext[PERI_IDX_LO +: 5]             = periIdx;
      statNext[7:0]                          = {CLS_PERI, 1'b0, periIdx};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= statNext;
  end

  always_comb begin
    unique case (strb.rdSel)
      2'd0:    rdData = ctrlWord;
      2'd1:    rdData = mainWord;
      2'd2:    rdData = periWord;
      default: rdData = stat;
    endcase
  end
endmodule

// File: rtl/ic_top.sv
module ic_top
  import ic_pkg::*;
#(
  parameter int NUM_MAIN = 17,
  parameter int NUM_PERI = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busSel,
  input  logic                busWe,
  input  logic [1:0]          busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] extPin,
  input  logic [NUM_MAIN-1:0] mainSrc,
  input  logic [NUM_PERI-1:0] periSrc,
  output logic                irq,
  output logic [DATA_W-1:0]   status
);
  icStrobe_t strb;

  ic_ctrl u_ctrl (
    .busSel  (busSel),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .strb    (strb)
  );

  ic_datapath #(.NUM_MAIN(NUM_MAIN), .NUM_PERI(NUM_PERI)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .extPin (extPin),
    .mainSrc(mainSrc),
    .periSrc(periSrc),
    .rdData (busRdata),
    .stat   (status)
  );

  assign irq = status[CRIT_FLAG] | status[MAIN_FLAG] | status[PERI_FLAG];
endmodule

// File: rtl/ic_chk.sv
module ic_chk
  import ic_pkg::*;
#(
  parameter int NUM_MAIN = 17,
  parameter int NUM_PERI = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                busSel,
  input logic                busWe,
  input logic [1:0]          busAddr,
  input logic [DATA_W-1:0]   busWdata,
  input logic [DATA_W-1:0]   busRdata,
  input logic [NUM_PINS-1:0] extPin,
  input logic [NUM_MAIN-1:0] mainSrc,
  input logic [NUM_PERI-1:0] periSrc,
  input logic                irq,
  input logic [DATA_W-1:0]   status
);
  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (status == '0) && !irq);

  // R9
  one_class_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({status[PERI_FLAG], status[MAIN_FLAG], status[CRIT_FLAG]}));

  // R6
  crit_code_chk: assert property (@(posedge clk) disable iff (rst)
    status[CRIT_FLAG] |-> (status[9:8] == 2'd0) && (status[7:0] == 8'h00));

  // R7
  main_code_chk: assert property (@(posedge clk) disable iff (rst)
    status[MAIN_FLAG] |-> (status[7:6] == CLS_MAIN) && (status[5:0] == {1'b0, status[20:16]}));

  // R8
  peri_code_chk: assert property (@(posedge clk) disable iff (rst)
    status[PERI_FLAG] |-> (status[7:6] == CLS_PERI) && (status[5:0] == {1'b0, status[28:24]}));

  // R12
  stat_read_chk: assert property (@(posedge clk) disable iff (rst)
    (busSel && !busWe && busAddr == 2'd3) |-> (busRdata == status));
endmodule

bind ic_top ic_chk #(.NUM_MAIN(NUM_MAIN), .NUM_PERI(NUM_PERI)) u_chk (.*);

// File: tb/sim_ic_top.sv
module sim_ic_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0, busWe = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  extPin = '0;
  logic [16:0] mainSrc = '0;
  logic [23:0] periSrc = '0;
  logic        irq;
  logic [31:0] status;

  int nChecks = 0, nErrors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ic_top u0 (.*);

  // behavioural reference model
  logic [31:0] mCtrl, mMain, mPeri, mStat;
  logic [3:0]  s1, s2, pv, lat;

  always @(posedge clk) begin : mdl
    logic [31:0] nStat;
    logic [3:0]  req, nLat;
    logic [16:0] mv;
    logic [1:0]  sn;
    bit          found;
    if (rst) begin
      mCtrl = 0; mMain = 0; mPeri = 0; mStat = 0;
      s1 = 0; s2 = 0; pv = 0; lat = 0;
    end else begin
      for (int n = 0; n < 4; n++) begin
        sn = mCtrl[23-2*n -: 2];
        if (sn == 2'b00)      req[n] = s2[n];
        else if (sn == 2'b11) req[n] = !s2[n];
        else                  req[n] = lat[n];
        req[n] = req[n] && mCtrl[11-n];
        if ((sn == 2'b01 && s2[n] && !pv[n]) || (sn == 2'b10 && !s2[n] && pv[n])) nLat[n] = 1;
        else if (busSel && busWe && busAddr == 0 && busWdata[27-n]) nLat[n] = 0;
        else nLat[n] = lat[n];
      end
      mv = mainSrc | {13'd0, req[3:1], 1'b0};
      nStat = 0;
      found = 0;
      if (req[0]) begin
        nStat = 32'h400; found = 1;
      end
      for (int n = 0; n < 17; n++)
        if (!found && mv[n] && !mMain[16-n]) begin
          nStat = 32'h200000 | (n << 16) | (64 + n); found = 1;
        end
      for (int n = 0; n < 24; n++)
        if (!found && periSrc[n] && !mPeri[31-n]) begin
          nStat = 32'h20000000 | (n << 24) | (128 + n); found = 1;
        end
      lat = nLat; pv = s2; s2 = s1; s1 = extPin;
      if (busSel && busWe) begin
        if (busAddr == 0) mCtrl = busWdata & 32'h00FF0F00;
        if (busAddr == 1) mMain = busWdata & 32'h0001FFFF;
        if (busAddr == 2) mPeri = busWdata & 32'hFFFFFF00;
      end
      mStat = nStat;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R11: every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R11 model status", status, mStat);
      chk("R11 irq", {31'd0, irq}, {31'd0, (mStat[10] | mStat[21] | mStat[29])});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWe = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWe = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : wd
    #(CLK_PERIOD * 100000);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 status", status, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 main mask", d, 0);
    rd(2, d); chk("R1 peri mask", d, 0);

    // R2: layout, clear bits read zero
    wr(0, 32'h0FE40F00);
    rd(0, d); chk("R2 ctrl readback", d, 32'h00E40F00);
    waitc(5);
    // R3 + R6: pin0 level-low with pin low -> critical
    chk("R3 level low active", status, 32'h00000400);
    chk("R6 critical code", status, 32'h00000400);
    extPin[0] = 1;
    waitc(5);
    chk("R3 level low released", status, 0);
    wr(0, 0);

    // R7/R8 mask storage
    wr(1, 32'hFFFFFFFF);
    rd(1, d); chk("R7 main mask bits", d, 32'h0001FFFF);
    wr(2, 32'hFFFFFFFF);
    rd(2, d); chk("R8 peri mask bits", d, 32'hFFFFFF00);

    mainSrc = 17'h00220;
    waitc(3);
    chk("R7 all masked", status, 0);
    wr(1, 32'h0001FF7F);
    waitc(2);
    chk("R7 main source 9", status, 32'h00290049);
    wr(1, 32'h0001F77F);
    waitc(2);
    chk("R10 lowest main wins", status, 32'h00250045);

    periSrc = 24'h100008;
    wr(2, 0);
    waitc(2);
    chk("R9 main over peri", status, 32'h00250045);
    wr(1, 32'h0001FFFF);
    waitc(2);
    chk("R8 peri source 3", status, 32'h23000083);
    wr(2, 32'h10000000);
    waitc(2);
    chk("R10 next peri", status, 32'h34000094);

    // R9 critical over peripheral: pin0 level high, pin0 is 1
    wr(0, 32'h00000800);
    waitc(5);
    chk("R9 crit over peri", status, 32'h00000400);
    chk("R11 irq high", {31'd0, irq}, 1);

    // R4 rising edge on pin1
    wr(1, 32'h00017FFF);
    wr(0, 32'h00100400);
    waitc(2);
    chk("R4 no event yet", status, 32'h34000094);
    extPin[1] = 1;
    waitc(3);
    extPin[1] = 0;
    waitc(6);
    chk("R4 sticky after pulse", status, 32'h00210041);
    wr(0, 32'h00100400);
    waitc(3);
    chk("R4 write zero keeps", status, 32'h00210041);
    wr(0, 32'h04100400);
    waitc(3);
    chk("R4 cleared", status, 32'h34000094);

    // R4 falling edge on pin2
    wr(1, 32'h00013FFF);
    wr(0, 32'h00080200);
    extPin[2] = 1;
    waitc(6);
    chk("R4 fall no event on rise", status, 32'h34000094);
    extPin[2] = 0;
    waitc(6);
    chk("R4 falling latched", status, 32'h00220042);
    wr(0, 32'h02000000);
    waitc(3);

    // R5 disabled pin
    wr(1, 32'h00011FFF);
    extPin[3] = 1;
    waitc(6);
    chk("R5 disabled pin ignored", status, 32'h34000094);
    wr(0, 32'h00000100);
    waitc(3);
    chk("R5 enabled pin3", status, 32'h00230043);

    // R12 status read and ignored write
    rd(3, d); chk("R12 status read", d, 32'h00230043);
    wr(3, 32'hFFFFFFFF);
    waitc(2);
    chk("R12 write ignored status", status, 32'h00230043);
    rd(1, d); chk("R12 write ignored mask", d, 32'h00011FFF);

    // R11 all clear
    extPin = '0; mainSrc = '0; periSrc = '0;
    wr(0, 0);
    waitc(5);
    chk("R11 idle", status, 0);
    chk("R11 irq low", {31'd0, irq}, 0);

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule